// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a small synchronous memory with byte-lane writes and four-beat bursts, built to sit behind a processor or cache controller that issues address strobes. Each rising clock edge the control path classifies the cycle as a deselect, a read or a write. It takes into account three chip enables, two address strobes, a burst advance input and the write controls. It then hands a cycle address and per-lane write strobes to the datapath. The datapath holds a parameterised register array and a registered read pipeline.

The two strobes behave differently. The processor strobe can only start a read, and only while the first chip enable is low. The controller strobe can start a read, start a write or deselect. Between strobes, the advance input either steps the two low address bits through a linear or interleaved four-beat order, or holds them. Each such cycle is again a read or a write. Read data comes from a registered output. The output drive flag is gated by an output enable and a sleep input, and both act at once.

Top module: `burst_sram_ctl`

## Requirements
- R1: The part is selected only when `ceN`=0, `ce2`=1 and `ce3N`=0. A strobe sampled while it is not selected ends any burst, writes nothing and produces no read data. Cycles without a strobe that follow it also do nothing until a new strobe selects the part.
- R2: A processor strobe (`adspN`=0) is honoured only while `ceN`=0. When honoured it always reads the new address, whatever `gwN`, `bweN` and `beN` are. With `ceN`=1 it is ignored and the cycle behaves as if no strobe were present.
- R3: A controller strobe (`adscN`=0, with no honoured processor strobe) with the part selected loads `addr`. It then reads or writes that address according to the write controls.
- R4: With no strobe and a burst active, `advN`=0 moves to the next burst address and `advN`=1 stays on the current one. The cycle reads or writes according to the write controls.
- R5: A cycle is a write when `gwN`=0, or when `bweN`=0 and at least one `beN` bit is 0. `gwN`=0 writes every lane. Lane n is `wdata` bits [9n+8:9n], and bit 9n+8 is its parity bit.
- R6: Lane n is written when `bweN`=0 and `beN[n]`=0. When `bweN`=1, the `beN` bits have no effect, and the cycle is a read unless `gwN`=0.
- R7: After a processor-strobe read, a following suspended cycle with write controls active writes the same address.
- R8: A read of an address in the cycle directly after a write to it returns the written data.
- R9: A read sampled at edge k puts its data on `rdata` with `rdataOe`=1 after edge k+1. That output holds until edge k+2, and `rdataOe` is 0 after any edge whose previous cycle was not a read.
- R10: Burst order, on the low two address bits with start s and beat i = 0..3: `linearMode`=1 gives (s+i) mod 4, and `linearMode`=0 gives s XOR i. The upper address bits stay fixed.
- R11: `oeN`=1 forces `rdataOe` to 0 at once, with no clock edge.
- R12: `sleep`=1 forces `rdataOe` to 0 at once. Clock edges that sample `sleep`=1 perform no read or write.
- R13: While `rst_n` is 0, and after it is released, `rdataOe` is 0 and the part is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | External address |
| wdata | input | NB*9 | Write data, 9-bit lanes with parity in the top bit |
| ceN | input | 1 | Chip enable, active low, also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| beN | input | NB | Per-lane write enables, active low |
| oeN | input | 1 | Output enable, active low, asynchronous |
| linearMode | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Standby, active high |
| rdata | output | NB*9 | Registered read data |
| rdataOe | output | 1 | Read data drive enable |

## Verification
Some properties are checked on every cycle. Deselect strobes, honoured processor strobes and cycles with both write enables high never raise a lane write. Output enable and sleep always hold the drive flag low, and the flag is raised only two edges after a read. Other behaviours need the bench's scenarios to show them. These are burst address order in both modes, byte-lane merging and write-through of data to the next read, and the processor-strobe read followed by a wait-cycle write. They also cover strobes that must be ignored, observed by reading the affected address back afterwards.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 9;

  typedef struct packed {
    logic doRead;
    logic doWrite;
  } cyc_ctl_t;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ceN,
  input  logic          ce2,
  input  logic          ce3N,
  input  logic          adspN,
  input  logic          adscN,
  input  logic          advN,
  input  logic          gwN,
  input  logic          bweN,
  input  logic [NB-1:0] beN,
  input  logic          linearMode,
  input  logic          sleep,
  output cyc_ctl_t      ctl,
  output logic [AW-1:0] cycAddr,
  output logic [NB-1:0] laneWe
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hiQ;
  logic [1:0]    startQ, beatQ;
  logic          active;

  logic          sel, pStart, cStart, load, desel, cont, wrReq;
  logic [1:0]    nextBeat, startNow, lowNow;
  logic [HW-1:0] hiNow;

  always_comb begin
    sel    = !ceN && ce2 && !ce3N;
    pStart = !adspN && !ceN;
    cStart = !adscN && !pStart;
    load   = (pStart || cStart) && sel;
    desel  = (pStart || cStart) && !sel;
    cont   = !pStart && !cStart && active;
    wrReq  = !gwN || (!bweN && !(&beN));

    ctl.doWrite = !sleep && ((cStart && sel) || cont) && wrReq;
    ctl.doRead  = !sleep && ((pStart && sel) || (((cStart && sel) || cont) && !wrReq));

    if (load)              nextBeat = 2'd0;
    else if (cont && !advN) nextBeat = beatQ + 2'd1;
    else                   nextBeat = beatQ;

    startNow = load ? addr[1:0] : startQ;
    hiNow    = load ? addr[AW-1:2] : hiQ;
    lowNow   = linearMode ? (startNow + nextBeat) : (startNow ^ nextBeat);
    cycAddr  = {hiNow, lowNow};
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign laneWe[g] = ctl.doWrite && (!gwN || (!bweN && !beN[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      hiQ    <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (!sleep) begin
      if (load) begin
        active <= 1'b1;
        hiQ    <= addr[AW-1:2];
        startQ <= addr[1:0];
        beatQ  <= 2'd0;
      end else if (desel) begin
        active <= 1'b0;
      end else if (cont) begin
        beatQ  <= nextBeat;
      end
    end
  end
endmodule

// File: rtl/bsram_data.sv
module bsram_data
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cyc_ctl_t             ctl,
  input  logic [AW-1:0]        cycAddr,
  input  logic [NB-1:0]        laneWe,
  input  logic [NB*LANE_W-1:0] wdata,
  input  logic                 oeN,
  input  logic                 sleep,
  output logic [NB*LANE_W-1:0] rdata,
  output logic                 rdataOe
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * LANE_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] memQ, rdReg;
  logic          rdValid, outValid;

  always_ff @(posedge clk) begin
    for (int n = 0; n < NB; n++) begin
      if (ctl.doWrite && laneWe[n])
        mem[cycAddr][n*LANE_W +: LANE_W] <= wdata[n*LANE_W +: LANE_W];
    end
    if (ctl.doRead) memQ <= mem[cycAddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValid  <= 1'b0;
      outValid <= 1'b0;
      rdReg    <= '0;
    end else begin
      rdValid  <= ctl.doRead;
      outValid <= rdValid;
      rdReg    <= memQ;
    end
  end

  assign rdata   = rdReg;
  assign rdataOe = outValid && !oeN && !sleep;
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import bsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        addr,
  input  logic [NB*LANE_W-1:0] wdata,
  input  logic                 ceN,
  input  logic                 ce2,
  input  logic                 ce3N,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NB-1:0]        beN,
  input  logic                 oeN,
  input  logic                 linearMode,
  input  logic                 sleep,
  output logic [NB*LANE_W-1:0] rdata,
  output logic                 rdataOe
);
  cyc_ctl_t      ctl;
  logic [AW-1:0] cycAddr;
  logic [NB-1:0] laneWe;

  bsram_ctrl #(.AW(AW), .NB(NB)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ceN(ceN), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN), .beN(beN),
    .linearMode(linearMode), .sleep(sleep), .ctl(ctl), .cycAddr(cycAddr), .laneWe(laneWe)
  );

  bsram_data #(.AW(AW), .NB(NB)) data_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cycAddr(cycAddr), .laneWe(laneWe),
    .wdata(wdata), .oeN(oeN), .sleep(sleep), .rdata(rdata), .rdataOe(rdataOe)
  );
endmodule

// File: rtl/burst_sram_ctl_chk.sv
module burst_sram_ctl_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ceN,
  input logic          ce2,
  input logic          ce3N,
  input logic          adspN,
  input logic          adscN,
  input logic          gwN,
  input logic          bweN,
  input logic          oeN,
  input logic          sleep,
  input logic          rdataOe,
  input logic          doRead,
  input logic [NB-1:0] laneWe
);
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adscN && !(!ceN && ce2 && !ce3N)) |-> (laneWe == '0)); // R1
  AST_PSTROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adspN && !ceN) |-> (laneWe == '0)); // R2
  AST_LANES_NEED_BWE: assert property (@(posedge clk) disable iff (!rst_n)
    (gwN && bweN) |-> (laneWe == '0)); // R6
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rdataOe |-> $past(doRead, 2)); // R9
  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |-> !rdataOe); // R11
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdataOe); // R12
endmodule

bind burst_sram_ctl burst_sram_ctl_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .ceN(ceN), .ce2(ce2), .ce3N(ce3N), .adspN(adspN),
  .adscN(adscN), .gwN(gwN), .bweN(bweN), .oeN(oeN), .sleep(sleep),
  .rdataOe(rdataOe), .doRead(ctl.doRead), .laneWe(laneWe)
);

// File: tb/burst_sram_ctl_tb_top.sv
module burst_sram_ctl_tb_top;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ceN = 1'b1, ce2 = 1'b1, ce3N = 1'b0, adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b0, linearMode = 1'b1, sleep = 1'b0;
  logic [NB-1:0] beN = '1;
  logic [DW-1:0] rdata;
  logic          rdataOe;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_sram_ctl #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ceN(ceN), .ce2(ce2),
    .ce3N(ce3N), .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .beN(beN), .oeN(oeN), .linearMode(linearMode), .sleep(sleep),
    .rdata(rdata), .rdataOe(rdataOe)
  );

  typedef struct packed {
    logic          pS, cS, adv, ce, c2, gw;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          eOe;
    logic [DW-1:0] eD;
  } vec_t;

  // controller-strobe writes and reads, suspend, deselect, idle
  localparam vec_t TBL [7] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h04, 18'h1A5A5, 1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h05, 18'h2C3C3, 1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'h04, 18'h0,     1'b0, 18'h0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'h05, 18'h0,     1'b1, 18'h1A5A5},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'h00, 18'h0,     1'b1, 18'h2C3C3},
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'h00, 18'h0,     1'b1, 18'h2C3C3},
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 6'h00, 18'h0,     1'b0, 18'h0}
  };

  task automatic chk(input string req, input logic expOe, input logic [DW-1:0] expD);
    nTests++;
    if (rdataOe !== expOe || (expOe && rdata !== expD)) begin
      nFail++;
      $display("FAIL %s: rdataOe=%b rdata=%h expected rdataOe=%b rdata=%h",
               req, rdataOe, rdata, expOe, expD);
    end
  endtask

  task automatic cyc(input logic pS, input logic cS, input logic adv, input logic ce,
                     input logic c2, input logic gw, input logic bwe, input logic [NB-1:0] be,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    adspN = pS; adscN = cS; advN = adv; ceN = ce; ce2 = c2;
    gwN = gw; bweN = bwe; beN = be; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 in reset", 1'b0, '0);
    rst_n = 1'b1;
    cyc(1, 1, 1, 1, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R13 after reset", 1'b0, '0);

    // table walk: R3 R4 R1 R9
    for (int i = 0; i < 7; i++) begin
      cyc(TBL[i].pS, TBL[i].cS, TBL[i].adv, TBL[i].ce, TBL[i].c2, TBL[i].gw,
          1'b1, 2'b11, TBL[i].a, TBL[i].d);
      chk($sformatf("R3/R4/R1/R9 row %0d", i), TBL[i].eOe, TBL[i].eD);
    end

    // R10 linear write burst from 0x11: 11,12,13,10
    linearMode = 1'b1;
    cyc(1, 0, 1, 0, 1, 0, 1, 2'b11, 6'h11, 18'h01111);
    cyc(1, 1, 0, 0, 1, 0, 1, 2'b11, 6'h00, 18'h02222);
    cyc(1, 1, 0, 0, 1, 0, 1, 2'b11, 6'h00, 18'h03333);
    cyc(1, 1, 0, 0, 1, 0, 1, 2'b11, 6'h00, 18'h04444);
    // R10 interleaved read from 0x11: 11,10,13,12
    linearMode = 1'b0;
    cyc(1, 0, 1, 0, 1, 1, 1, 2'b11, 6'h11, '0);
    cyc(1, 1, 0, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 interleaved beat0", 1'b1, 18'h01111);
    cyc(1, 1, 0, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 interleaved beat1", 1'b1, 18'h04444);
    cyc(1, 1, 0, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 interleaved beat2", 1'b1, 18'h03333);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 interleaved beat3", 1'b1, 18'h02222);
    // R10 linear wrap from 0x13 to 0x10
    linearMode = 1'b1;
    cyc(1, 0, 1, 0, 1, 1, 1, 2'b11, 6'h13, '0);
    cyc(1, 1, 0, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 linear beat0", 1'b1, 18'h03333);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R10 linear wrap", 1'b1, 18'h04444);

    // R5 R6 R8 byte lanes
    cyc(1, 0, 1, 0, 1, 0, 1, 2'b11, 6'h20, 18'h3FFFF);
    cyc(1, 1, 1, 0, 1, 1, 0, 2'b10, 6'h00, 18'h00000);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b00, 6'h00, 18'h00000);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R6 R8 lane0 write, enables ignored without bweN", 1'b1, 18'h3FE00);
    cyc(1, 1, 1, 0, 1, 1, 0, 2'b01, 6'h00, 18'h00000);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R5 R6 lane1 with parity cleared", 1'b1, 18'h00000);

    // R2 R7 processor strobe reads despite gwN, wait cycle writes
    cyc(1, 0, 1, 0, 1, 0, 1, 2'b11, 6'h30, 18'h15555);
    cyc(0, 1, 1, 0, 1, 0, 1, 2'b11, 6'h30, 18'h0AAAA);
    cyc(1, 1, 1, 0, 1, 0, 1, 2'b11, 6'h00, 18'h0AAAA);
    chk("R2 processor strobe read old data", 1'b1, 18'h15555);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R9 no drive after write cycle", 1'b0, '0);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R7 wait-cycle write landed", 1'b1, 18'h0AAAA);

    // R2 processor strobe ignored with ceN high
    cyc(0, 1, 1, 1, 1, 1, 1, 2'b11, 6'h04, '0);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R2 gated strobe ignored", 1'b1, 18'h0AAAA);
    // R1 controller strobe with ceN high deselects, no write
    cyc(1, 0, 1, 1, 1, 0, 1, 2'b11, 6'h30, 18'h00000);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R1 deselected idle", 1'b0, '0);
    cyc(1, 0, 1, 0, 1, 1, 1, 2'b11, 6'h30, '0);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R1 no write while deselected", 1'b1, 18'h0AAAA);

    // R11 asynchronous output enable
    oeN = 1'b1; #1;
    chk("R11 oeN high", 1'b0, '0);
    oeN = 1'b0; #1;
    chk("R11 oeN low", 1'b1, 18'h0AAAA);

    // R12 sleep
    sleep = 1'b1; #1;
    chk("R12 sleep disables", 1'b0, '0);
    cyc(1, 0, 1, 0, 1, 0, 1, 2'b11, 6'h04, 18'h00000);
    sleep = 1'b0;
    cyc(1, 0, 1, 0, 1, 1, 1, 2'b11, 6'h04, '0);
    cyc(1, 1, 1, 0, 1, 1, 1, 2'b11, 6'h00, '0);
    chk("R12 write during sleep ignored", 1'b1, 18'h1A5A5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule